// File: doc/BRIEF.md
# Comparator duty-cycle rate generator

This block produces the enable strobe that decides when a pair of battery-threshold comparators is allowed to sample. It runs from a single-cycle tick that arrives at 1024 Hz and is configured through one control byte. The byte has three fields: a two-bit mode, a three-bit prescaler exponent code and a three-bit divider code.

There are four modes. The output can be held off, can follow an external signal that reports an active crystal oscillator, can be held on, or can be driven by the internal rate generator. In rate mode the update period is the divider times two raised to the exponent, counted in ticks. Both factors are stored with an offset. The output is high for exactly one tick interval in each period. Every write to the control byte restarts the counter chain, so each new setting begins a whole period from the write.

Top module: `cdr_rate_gen`

## Requirements
- R1: After reset the control byte is 0xBF. This is rate mode with exponent 9 and divider 8. The first strobe follows the 4096th tick after reset.
- R2: With mode bits [7:6] = 00 the output `comp_en` is low, whatever the ticks or `xo_active` do.
- R3: With mode bits [7:6] = 01 the output `comp_en` equals `xo_active`.
- R4: With mode bits [7:6] = 11 the output `comp_en` is high.
- R5: With mode bits [7:6] = 10 the period is N = D * 2^E ticks. E is bits [5:3] + 2 and D is bits [2:0] + 1. `comp_en` goes high at the clock edge that takes the N-th tick of each period. It stays high until the edge that takes the next tick.
- R6: A divider code of 0 in bits [2:0] acts as divider 2, the same as code 1.
- R7: A write to the control byte clears the strobe and both counters at the same edge. The first strobe after the write follows the N-th tick after it.
- R8: A tick that arrives in the same cycle as a control write is not counted.
- R9: In rate mode `comp_en` changes only at an edge that takes a tick or a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1k | input | 1 | One-cycle pulse at the 1024 Hz rate |
| cfg_wr | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte value: mode [7:6], exponent code [5:3], divider code [2:0] |
| xo_active | input | 1 | Crystal oscillator running, used in mode 01 |
| comp_en | output | 1 | Comparator enable strobe |

## Verification
Rate mode is driven with several settings. The smallest period (8 ticks) shows the one-tick pulse width and that the output repeats. Exponent code 2 with divider code 4 gives 80 ticks, which separates the prescaler factor from the divider factor. The reset default of 4096 ticks shows that the counters reach their full width. Divider codes 0 and 1 are run one after the other, and they must give the same period. Further cases are a rewrite partway through a period, a rewrite while the strobe is high, and a write that arrives with a tick. Each static mode is run with the crystal-active input toggling and with ticks arriving, so that a mode which wrongly follows either one would be seen.

// File: rtl/cdr_pkg.sv
package cdr_pkg;

  localparam int CODE_W     = 3;
  localparam int EXP_OFFSET = 2;
  localparam int DIV_OFFSET = 1;
  localparam int MAX_EXP    = EXP_OFFSET + (1 << CODE_W) - 1;
  localparam int PRE_W      = MAX_EXP;
  localparam int DIV_W      = CODE_W;
  localparam int CFG_W      = 2 + 2 * CODE_W;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_XO   = 2'b01,
    MODE_RATE = 2'b10,
    MODE_ON   = 2'b11
  } cdr_mode_e;

  typedef struct packed {
    cdr_mode_e         mode;
    logic [CODE_W-1:0] exp_code;
    logic [CODE_W-1:0] div_code;
  } cdr_cfg_t;

  // Exponent of the prescaler for a stored code.
  function automatic int exp_of(input logic [CODE_W-1:0] code);
    return int'(code) + EXP_OFFSET;
  endfunction

  // Divider for a stored code. Code 0 is taken as the smallest legal divider.
  function automatic int div_of(input logic [CODE_W-1:0] code);
    if (code == '0) return 1 + DIV_OFFSET;
    return int'(code) + DIV_OFFSET;
  endfunction

  // Terminal count of the prescaler: 2^E - 1, built as a mask of ones.
  function automatic logic [PRE_W-1:0] pre_last(input logic [CODE_W-1:0] code);
    logic [PRE_W-1:0] r;
    int e;
    e = exp_of(code);
    for (int i = 0; i < PRE_W; i++) r[i] = (i < e);
    return r;
  endfunction

  // Terminal count of the divider: D - 1.
  function automatic logic [DIV_W-1:0] div_last(input logic [CODE_W-1:0] code);
    if (code == '0) return DIV_W'(1);
    return DIV_W'(code);
  endfunction

endpackage

// File: rtl/cdr_cfg_reg.sv
module cdr_cfg_reg
  import cdr_pkg::*;
#(
  parameter logic [CFG_W-1:0] RESET_CFG = 8'hBF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wdata,
  output cdr_cfg_t         cfg_q,
  output logic             restart
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= cdr_cfg_t'(RESET_CFG);
    else if (wr_en) cfg_q <= cdr_cfg_t'(wdata);
  end

  // The counters restart at the same edge that loads the new byte.
  assign restart = wr_en;

endmodule

// File: rtl/cdr_prescaler.sv
module cdr_prescaler #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         restart,
  input  logic         tick,
  input  logic [W-1:0] last,
  output logic [W-1:0] cnt,
  output logic         wrap
);

  logic at_last;
  assign at_last = (cnt == last);
  assign wrap    = run && !restart && tick && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (restart || !run)  cnt <= '0;
    else if (tick)             cnt <= at_last ? '0 : cnt + W'(1);
  end

endmodule

// File: rtl/cdr_divider.sv
module cdr_divider #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         restart,
  input  logic         step,
  input  logic [W-1:0] last,
  output logic [W-1:0] cnt,
  output logic         period_end
);

  logic at_last;
  assign at_last    = (cnt == last);
  assign period_end = run && !restart && step && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (restart || !run) cnt <= '0;
    else if (step)            cnt <= at_last ? '0 : cnt + W'(1);
  end

endmodule

// File: rtl/cdr_rate_gen.sv
module cdr_rate_gen
  import cdr_pkg::*;
#(
  parameter logic [7:0] RESET_CFG = 8'hBF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1k,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_wdata,
  input  logic       xo_active,
  output logic       comp_en
);

  cdr_cfg_t         cfg_q;
  logic             restart;
  logic             run;
  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] pre_lim;
  logic             pre_done;
  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] div_lim;
  logic             period_end;
  logic             strobe_q;

  cdr_cfg_reg #(.RESET_CFG(RESET_CFG)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr),
    .wdata   (cfg_wdata),
    .cfg_q   (cfg_q),
    .restart (restart)
  );

  assign run     = (cfg_q.mode == MODE_RATE);
  assign pre_lim = pre_last(cfg_q.exp_code);
  assign div_lim = div_last(cfg_q.div_code);

  cdr_prescaler #(.W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (restart),
    .tick    (tick_1k),
    .last    (pre_lim),
    .cnt     (pre_cnt),
    .wrap    (pre_done)
  );

  cdr_divider #(.W(DIV_W)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .restart    (restart),
    .step       (pre_done),
    .last       (div_lim),
    .cnt        (div_cnt),
    .period_end (period_end)
  );

  // One-tick pulse: set by the tick that ends a period, cleared by the next tick.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               strobe_q <= 1'b0;
    else if (restart || !run) strobe_q <= 1'b0;
    else if (tick_1k)         strobe_q <= period_end;
  end

  always_comb begin
    unique case (cfg_q.mode)
      MODE_OFF:  comp_en = 1'b0;
      MODE_XO:   comp_en = xo_active;
      MODE_RATE: comp_en = strobe_q;
      MODE_ON:   comp_en = 1'b1;
      default:   comp_en = 1'b0;
    endcase
  end

endmodule

// File: rtl/cdr_rate_gen_chk.sv
module cdr_rate_gen_chk
  import cdr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tick_1k,
  input logic             cfg_wr,
  input logic [7:0]       cfg_wdata,
  input logic             xo_active,
  input logic             comp_en,
  input logic             strobe_q,
  input logic             pre_done,
  input logic             period_end,
  input logic [PRE_W-1:0] pre_cnt,
  input logic [PRE_W-1:0] pre_lim,
  input logic [DIV_W-1:0] div_cnt
);

  p_never_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_wdata[7:6] == 2'b00) |=> !comp_en);

  p_xo_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_wdata[7:6] == 2'b01) |=> (comp_en == xo_active));

  p_always_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_wdata[7:6] == 2'b11) |=> comp_en);

  p_end_needs_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |-> pre_done);

  p_pre_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cnt <= pre_lim);

  p_pulse_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_q && !tick_1k && !cfg_wr) |=> strobe_q);

  p_pulse_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_q && tick_1k && !cfg_wr) |=> !strobe_q);

  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (!strobe_q && pre_cnt == '0 && div_cnt == '0));

  p_tick_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && tick_1k) |=> (pre_cnt == '0));

  p_edge_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_1k && !cfg_wr) |=> $stable(strobe_q));

endmodule

bind cdr_rate_gen cdr_rate_gen_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_1k    (tick_1k),
  .cfg_wr     (cfg_wr),
  .cfg_wdata  (cfg_wdata),
  .xo_active  (xo_active),
  .comp_en    (comp_en),
  .strobe_q   (strobe_q),
  .pre_done   (pre_done),
  .period_end (period_end),
  .pre_cnt    (pre_cnt),
  .pre_lim    (pre_lim),
  .div_cnt    (div_cnt)
);

// File: tb/sim_cdr_rate_gen.sv
module sim_cdr_rate_gen;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_GAP   = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1k = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       xo_active = 1'b0;
  logic       comp_en;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  cdr_rate_gen u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_1k   (tick_1k),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .xo_active (xo_active),
    .comp_en   (comp_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", req, what, got, exp, $time);
    end
  endtask

  // Rate period restated from the requirement text.
  function automatic int period_of(input logic [7:0] b);
    int e, d;
    e = b[5:3] + 2;
    d = (b[2:0] == 3'd0) ? 2 : b[2:0] + 1;
    return d * (1 << e);
  endfunction

  task automatic tick_once();
    @(negedge clk); tick_1k = 1'b1;
    @(negedge clk); tick_1k = 1'b0;
    repeat (TICK_GAP - 2) @(negedge clk);
  endtask

  task automatic write_cfg(input logic [7:0] b);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = b;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic run_periods(input logic [7:0] b, input int nper, input string req);
    int n;
    n = period_of(b);
    for (int k = 1; k <= n * nper; k++) begin
      tick_once();
      chk(comp_en, (k % n) == 0, req, $sformatf("cfg %02h tick %0d", b, k));
    end
  endtask

  task automatic t_reset_default();
    chk(comp_en, 1'b0, "R1", "after reset");
    for (int k = 1; k <= 4097; k++) begin
      tick_once();
      if (k >= 4094) chk(comp_en, k == 4096, "R1", $sformatf("default tick %0d", k));
      else if (comp_en !== 1'b0) chk(comp_en, 1'b0, "R1", $sformatf("default tick %0d", k));
    end
  endtask

  task automatic t_off_mode();
    write_cfg(8'h00);
    xo_active = 1'b1;
    for (int k = 0; k < 12; k++) begin
      tick_once();
      chk(comp_en, 1'b0, "R2", "off mode");
    end
    xo_active = 1'b0;
  endtask

  task automatic t_xo_mode();
    write_cfg(8'h7F);
    xo_active = 1'b0; #1;
    chk(comp_en, 1'b0, "R3", "xo low");
    xo_active = 1'b1; #1;
    chk(comp_en, 1'b1, "R3", "xo high");
    tick_once();
    chk(comp_en, 1'b1, "R3", "xo high after tick");
    xo_active = 1'b0; #1;
    chk(comp_en, 1'b0, "R3", "xo back low");
  endtask

  task automatic t_on_mode();
    write_cfg(8'hC0);
    chk(comp_en, 1'b1, "R4", "on mode");
    for (int k = 0; k < 10; k++) begin
      tick_once();
      chk(comp_en, 1'b1, "R4", "on mode with ticks");
    end
  endtask

  task automatic t_rate_small();
    write_cfg(8'h81);
    chk(comp_en, 1'b0, "R5", "after write");
    run_periods(8'h81, 3, "R5");
  endtask

  task automatic t_rate_mixed();
    write_cfg(8'h94);
    run_periods(8'h94, 2, "R5");
  endtask

  task automatic t_div_zero();
    write_cfg(8'h80);
    run_periods(8'h80, 2, "R6");
  endtask

  task automatic t_restart_mid();
    write_cfg(8'h81);
    repeat (5) tick_once();
    write_cfg(8'h81);
    for (int k = 1; k <= 8; k++) begin
      tick_once();
      chk(comp_en, k == 8, "R7", $sformatf("after rewrite tick %0d", k));
    end
    write_cfg(8'h81);
    chk(comp_en, 1'b0, "R7", "write clears high strobe");
  endtask

  task automatic t_tick_with_write();
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = 8'h81; tick_1k = 1'b1;
    @(negedge clk); cfg_wr = 1'b0; tick_1k = 1'b0;
    repeat (TICK_GAP - 2) @(negedge clk);
    for (int k = 1; k <= 8; k++) begin
      tick_once();
      chk(comp_en, k == 8, "R8", $sformatf("coincident tick ignored, tick %0d", k));
    end
  endtask

  task automatic t_edge_only();
    write_cfg(8'h81);
    repeat (7) tick_once();
    @(negedge clk); tick_1k = 1'b1;
    @(negedge clk); tick_1k = 1'b0;
    chk(comp_en, 1'b1, "R9", "high right after tick edge");
    @(negedge clk);
    chk(comp_en, 1'b1, "R9", "held between ticks");
    @(negedge clk);
    chk(comp_en, 1'b1, "R9", "still held between ticks");
    tick_once();
    chk(comp_en, 1'b0, "R9", "dropped at next tick");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_default();
    t_off_mode();
    t_xo_mode();
    t_on_mode();
    t_rate_small();
    t_rate_mixed();
    t_div_zero();
    t_restart_mid();
    t_tick_with_write();
    t_edge_only();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

endmodule